// File: doc/BRIEF.md
# Serial Start-of-Frame Finder and Byte Framer

This block sits on the receive side of a serial link. It takes the recovered NRZ bit stream, a one-cycle enable that marks each valid bit time, and a carrier-present flag. While carrier is up, it looks through the alternating 1,0 lead-in for the delimiter 1,0,1,0,1,0,1,1. The delimiter counts as found when two ones arrive on consecutive bit times. The block then raises a frame marker and holds it high.

From the bit after the delimiter onward, the stream is packed into bytes, least significant bit first. Each complete byte is presented on a parallel output with a one-cycle valid strobe and a running byte index. Downstream matching logic can therefore pick out the destination address, the source address and the type/length field by their index.

When carrier falls, the block drops the marker, clears the index, discards any partial byte and starts looking for a delimiter again.

Top module: `sfd_byte_framer`

## Requirements
- R1: After reset, `frame_mark`, `byte_vld`, `byte_out` and `byte_idx` are all zero.
- R2: While looking for the delimiter with carrier high, `frame_mark` goes to 1 in the cycle after the clock edge that samples the second of two consecutive enabled bits equal to 1. It stays at 1 until carrier drops.
- R3: A 1 followed by a 0 never sets `frame_mark`, so an alternating 1,0 lead-in of any length leaves it at 0. A 1 sampled before a carrier loss does not pair with a 1 sampled after it.
- R4: After the delimiter, bits are packed least significant bit first: the first enabled bit after the delimiter lands in `byte_out[0]` and the eighth lands in `byte_out[7]`.
- R5: `byte_vld` is a single-cycle pulse in the cycle after every eighth enabled bit that follows the delimiter, and it is never high at any other time. `byte_out` holds its value between strobes.
- R6: With each strobe, `byte_idx` gives the position of the presented byte in the frame. The first byte is 0 and each later byte adds 1. The index saturates at 2^IDX_W-1, which is 63 by default.
- R7: In a cycle with `bit_en` low, the value of `bit_in` is ignored and no output changes.
- R8: Carrier low at a clock edge gives `frame_mark`=0, `byte_vld`=0 and `byte_idx`=0 in the next cycle, and discards any partial byte. Enabled bits that arrive while carrier is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Marks a cycle that carries a valid recovered bit |
| bit_in | input | 1 | Recovered NRZ data bit |
| carrier | input | 1 | Receive carrier present |
| frame_mark | output | 1 | High from delimiter detection until carrier loss |
| byte_out | output | BYTE_W | Last completed byte, LSB received first |
| byte_vld | output | 1 | One-cycle strobe for each completed byte |
| byte_idx | output | IDX_W | Position of the presented byte in the frame (saturating) |

## Verification
The hardest cases to reach from the ports are the ones where the pairing memory or the partial byte must be thrown away. One such case is a 1 sampled just before carrier drops, then a 1 just after carrier returns. Another is a frame cut off partway through a byte, followed by a fresh frame. The stimulus sets up both cases on purpose and checks that no false delimiter and no misaligned first byte appears. Bits are also sent with idle gaps that carry the wrong data value, which exposes any sampling outside enabled cycles. A frame longer than 64 bytes pushes the index into saturation.

// File: rtl/sfd_framer_pkg.sv
package sfd_framer_pkg;
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } frm_state_t;

  // Two ones on consecutive enabled bit times close the delimiter.
  function automatic logic pair_closes(input logic prev_one, input logic cur_bit);
    return prev_one & cur_bit;
  endfunction
endpackage

// File: rtl/sfd_pair_hunter.sv
module sfd_pair_hunter (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic bit_in,
  output logic sfd_hit
);
  import sfd_framer_pkg::*;

  logic prev_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_one <= 1'b0;
    else if (clr)  prev_one <= 1'b0;
    else if (take) prev_one <= bit_in;
  end

  assign sfd_hit = take & pair_closes(prev_one, bit_in);
endmodule

// File: rtl/frm_deser.sv
module frm_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              bit_in,
  output logic              byte_done,
  output logic [BYTE_W-1:0] next_byte
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [BYTE_W-1:0] shift_lsb_first(
    input logic [BYTE_W-1:0] a, input logic b);
    return {b, a[BYTE_W-1:1]};
  endfunction

  assign next_byte = shift_lsb_first(acc, bit_in);
  assign byte_done = take && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clr) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      acc <= next_byte;
      cnt <= byte_done ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/byte_indexer.sv
module byte_indexer #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [IDX_W-1:0] TOP = '1;

  function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur_idx <= '0;
    else if (clr)  cur_idx <= '0;
    else if (adv)  cur_idx <= sat_inc(cur_idx);
  end
endmodule

// File: rtl/sfd_byte_framer.sv
module sfd_byte_framer #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              carrier,
  output logic              frame_mark,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic [IDX_W-1:0]  byte_idx
);
  import sfd_framer_pkg::*;

  frm_state_t        state;
  logic              clr_all;
  logic              hunt_take;
  logic              frame_take;
  logic              sfd_hit;
  logic              byte_done;
  logic [BYTE_W-1:0] next_byte;
  logic [IDX_W-1:0]  cur_idx;

  assign clr_all    = !carrier;
  assign hunt_take  = carrier && bit_en && (state == ST_HUNT);
  assign frame_take = carrier && bit_en && (state == ST_FRAME);

  sfd_pair_hunter u_hunt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_all),
    .take    (hunt_take),
    .bit_in  (bit_in),
    .sfd_hit (sfd_hit)
  );

  frm_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_all),
    .take      (frame_take),
    .bit_in    (bit_in),
    .byte_done (byte_done),
    .next_byte (next_byte)
  );

  byte_indexer #(.IDX_W(IDX_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_all),
    .adv     (byte_done),
    .cur_idx (cur_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= ST_HUNT;
    else if (clr_all)  state <= ST_HUNT;
    else if (sfd_hit)  state <= ST_FRAME;
  end

  assign frame_mark = (state == ST_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_vld <= 1'b0;
      byte_out <= '0;
      byte_idx <= '0;
    end else begin
      byte_vld <= byte_done;
      if (byte_done) begin
        byte_out <= next_byte;
        byte_idx <= cur_idx;
      end else if (clr_all) begin
        byte_idx <= '0;
      end
    end
  end
endmodule

// File: rtl/sfd_framer_chk.sv
module sfd_framer_chk #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              bit_in,
  input logic              carrier,
  input logic              sfd_hit,
  input logic              frame_mark,
  input logic              byte_vld,
  input logic [BYTE_W-1:0] byte_out,
  input logic [IDX_W-1:0]  byte_idx
);
  localparam int CW = $clog2(BYTE_W) + 1;
  localparam logic [IDX_W-1:0] IMAX = '1;

  logic [CW-1:0]    chk_cnt;
  logic [IDX_W-1:0] chk_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       chk_cnt <= '0;
    else if (!carrier || !frame_mark) chk_cnt <= '0;
    else if (bit_en)                  chk_cnt <= (chk_cnt == CW'(BYTE_W - 1)) ? '0 : chk_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             chk_bytes <= '0;
    else if (!carrier)                      chk_bytes <= '0;
    else if (byte_vld && chk_bytes != IMAX) chk_bytes <= chk_bytes + 1'b1;
  end

  assert_mark_needs_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_mark) |-> $past(carrier && bit_en && bit_in));

  assert_hit_only_hunting_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_hit |-> !frame_mark);

  assert_strobe_on_eighth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(frame_mark && carrier && bit_en && chk_cnt == CW'(BYTE_W - 1)));

  assert_index_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> byte_idx == chk_bytes);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && carrier) |=> ($stable(byte_out) && !byte_vld && $stable(frame_mark)));

  assert_carrier_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier |=> (!frame_mark && !byte_vld && byte_idx == '0));
endmodule

bind sfd_byte_framer sfd_framer_chk #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .bit_in     (bit_in),
  .carrier    (carrier),
  .sfd_hit    (sfd_hit),
  .frame_mark (frame_mark),
  .byte_vld   (byte_vld),
  .byte_out   (byte_out),
  .byte_idx   (byte_idx)
);

// File: tb/sim_sfd_byte_framer.sv
`timescale 1ns/1ps
module sim_sfd_byte_framer;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n, bit_en, bit_in, carrier;
  logic       frame_mark, byte_vld;
  logic [7:0] byte_out;
  logic [IW-1:0] byte_idx;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  int exp_idx = 0;
  logic [IW+7:0] exp_q[$];

  always #2.5 clk = ~clk;

  sfd_byte_framer #(.BYTE_W(8), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .carrier(carrier),
    .frame_mark(frame_mark), .byte_out(byte_out), .byte_vld(byte_vld), .byte_idx(byte_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one enabled bit, preceded by 'gap' idle cycles carrying the wrong value (R7)
  task automatic drive_bit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      bit_en = 1'b0; bit_in = ~b;
      @(negedge clk);
    end
    bit_en = 1'b1; bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_lead(input int pairs);
    for (int p = 0; p < pairs; p++) begin
      drive_bit(1'b1, 0);
      drive_bit(1'b0, 0);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    exp_q.push_back({IW'(exp_idx), b});
    if (exp_idx < (1 << IW) - 1) exp_idx++;
    for (int i = 0; i < 8; i++) drive_bit(b[i], gap);
  endtask

  task automatic drop_carrier();
    carrier = 1'b0;
    @(negedge clk);
    exp_idx = 0;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && byte_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected strobe", 1, 0);
      end else begin
        logic [IW+7:0] e;
        e = exp_q.pop_front();
        chk(byte_out == e[7:0], "R4 byte value", byte_out, e[7:0]);
        chk(byte_idx == e[IW+7:8], "R6 byte index", byte_idx, e[IW+7:8]);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog timeout", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; carrier = 1'b0;
    repeat (4) @(negedge clk);
    chk(frame_mark == 0, "R1 mark at reset", frame_mark, 0);
    chk(byte_vld == 0,   "R1 strobe at reset", byte_vld, 0);
    chk(byte_out == 0,   "R1 byte at reset", byte_out, 0);
    chk(byte_idx == 0,   "R1 index at reset", byte_idx, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // alternating lead-in, then closing ones
    carrier = 1'b1;
    send_lead(8);
    chk(frame_mark == 0, "R3 lead-in no mark", frame_mark, 0);
    drive_bit(1'b1, 0);
    chk(frame_mark == 0, "R3 single one no mark", frame_mark, 0);
    drive_bit(1'b1, 0);
    chk(frame_mark == 1, "R2 mark after two ones", frame_mark, 1);

    send_byte(8'hA5, 0);
    send_byte(8'h3C, 0);
    send_byte(8'hFF, 0);
    send_byte(8'h01, 0);
    repeat (3) @(negedge clk);
    chk(byte_out == 8'h01, "R5 byte held", byte_out, 8'h01);
    chk(frame_mark == 1,   "R2 mark held", frame_mark, 1);

    // sparse enables with wrong data in gaps
    send_byte(8'h96, 2);
    send_byte(8'h5A, 3);

    drop_carrier();
    chk(frame_mark == 0, "R8 mark cleared", frame_mark, 0);
    chk(byte_idx == 0,   "R8 index cleared", byte_idx, 0);
    chk(byte_vld == 0,   "R8 no strobe", byte_vld, 0);

    // enabled ones while carrier low are ignored
    drive_bit(1'b1, 0);
    drive_bit(1'b1, 0);
    chk(frame_mark == 0, "R8 bits ignored without carrier", frame_mark, 0);

    // a one before a carrier loss does not pair with a one after
    carrier = 1'b1;
    drive_bit(1'b1, 0);
    drop_carrier();
    carrier = 1'b1;
    drive_bit(1'b1, 0);
    chk(frame_mark == 0, "R3 no pairing across carrier loss", frame_mark, 0);
    drive_bit(1'b0, 0);
    drive_bit(1'b1, 1);
    drive_bit(1'b1, 2);
    chk(frame_mark == 1, "R2 mark with gapped ones", frame_mark, 1);

    // partial byte then carrier loss, new frame must align afresh
    for (int i = 0; i < 5; i++) drive_bit(i[0], 0);
    drop_carrier();
    carrier = 1'b1;
    send_lead(3);
    drive_bit(1'b1, 0);
    drive_bit(1'b1, 0);
    send_byte(8'hC3, 0);
    send_byte(8'h18, 1);

    // long frame: index saturation
    drop_carrier();
    carrier = 1'b1;
    send_lead(2);
    drive_bit(1'b1, 0);
    drive_bit(1'b1, 0);
    for (int n = 0; n < 66; n++) send_byte(8'(n * 7 + 1), 0);
    repeat (3) @(negedge clk);
    chk(byte_idx == 63, "R6 index saturated", byte_idx, 63);
    drop_carrier();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 missing strobes", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule